// File: doc/BRIEF.md
# Serial Calibration and Configuration Port

This block is the serial slave front end of a measurement converter. It holds three 32-bit words that the converter core consumes: an offset correction, a gain correction and a configuration word. A host reaches them through a four-wire serial link. Data moves most significant bit first. The block samples MOSI on rising SCLK edges while chip select is low, and it changes MISO on falling edges. Every transaction begins with an 8-bit command that picks a word and a direction. Exactly 32 data bits follow the command.

The block has no power-on reset. The host first sends a recovery pattern: a long run of ones ending in a zero, which is at least fifteen 0xFF bytes and then 0xFE. This pattern forces the port back to waiting for a command, from any state and at any bit phase. The host then writes the configuration word with its soft-reset bit set, which loads the default values into all three words. The converter core uses the two configuration flags and the two correction words directly from the output ports.

Top module: `serial_cmd_port`

## Requirements
- R1: In command mode the next 8 bits form a command. Bits [7:4] and bit 0 must be zero. Bits [2:1] select the word: 0 is offset, 1 is gain, 2 is configuration. Bit 3 is 1 for a read and 0 for a write. A valid command is followed by exactly 32 data bits, and then the port returns to command mode.
- R2: A command byte with any other value is discarded. This includes word select 3. The port stays in command mode, so the next 8 bits form a new command, and no word changes.
- R3: A write updates the selected word on its output port at the rising edge that samples the 32nd data bit. While the port is in command mode, no word changes.
- R4: After a read command, MISO presents the selected word MSB first. The first bit is valid after the falling edge that follows the last command bit, and each further falling edge advances one bit. MISO is 0 during writes, during commands and while chip select is high.
- R5: Gain is unsigned fixed point with 6 integer bits and 24 fraction bits. Bits [31:30] always read as zero, whatever value is written.
- R6: At least 127 consecutive 1 bits on MOSI followed by a 0 return the port to command mode. The bit after the 0 is taken as the first command bit, whatever the previous bit phase or mode. The run counter saturates, so arbitrarily long runs still qualify.
- R7: A run of 126 or fewer ones followed by a 0 has no effect on the bit phase. An example is 3 stray ones, fourteen 0xFF bytes and 0xFE.
- R8: Writing the configuration word with bit 29 set sets offset to 0x00000000, gain to 0x01000000 (1.0) and configuration to 0x00000000 at that same edge. Bit 29 never reads back as 1.
- R9: Configuration bit 27 drives `input_short` and bit 25 drives `vref_sel`. Every other configuration bit is stored exactly as written.
- R10: While chip select is high, SCLK edges are ignored and a partial transaction keeps its progress. It completes when chip select returns low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all state is clocked by it |
| cs_n | input | 1 | Active-low chip select; high pauses the port |
| mosi | input | 1 | Serial data in, sampled on rising edges |
| miso | output | 1 | Serial data out, changes on falling edges |
| offset_cal | output | 32 | Offset correction word |
| gain_cal | output | 32 | Gain correction word, 6.24 unsigned |
| cfg_word | output | 32 | Configuration word |
| input_short | output | 1 | Configuration flag that shorts the analog input |
| vref_sel | output | 1 | Configuration flag selecting the reference range |

## Verification
The bench builds the block with its default parameters: 32-bit words, 8-bit commands and a fifteen-byte recovery pattern, which gives a 127-bit run threshold. With these values, a threshold-minus-five run and a run several times past the counter's saturation point both fit in a few hundred cycles. A deliberately misaligned bit phase then shows whether recovery happened, because a later write lands only if the phase was restored. The fixed-point gain width leaves two unused upper bits, so clearing them on write can be observed.

// File: rtl/serial_cmd_port.sv
`timescale 1ns/1ps
module serial_cmd_port #(
  parameter int DATA_W       = 32,
  parameter int CMD_W        = 8,
  parameter int RESYNC_BYTES = 15,
  parameter int GAIN_INT     = 6,
  parameter int GAIN_FRAC    = 24,
  parameter int SRST_BIT     = 29,
  parameter int SHORT_BIT    = 27,
  parameter int VREF_BIT     = 25
) (
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic [DATA_W-1:0] offset_cal,
  output logic [DATA_W-1:0] gain_cal,
  output logic [DATA_W-1:0] cfg_word,
  output logic              input_short,
  output logic              vref_sel
);
  localparam int CNT_W    = $clog2(DATA_W);
  localparam int ONES_MAX = RESYNC_BYTES * 8 + 7;
  localparam int ONES_W   = $clog2(ONES_MAX + 1);
  localparam int GAIN_W   = GAIN_INT + GAIN_FRAC;
  localparam logic [DATA_W-1:0] ONE_W     = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] GAIN_ONE  = ONE_W << GAIN_FRAC;
  localparam logic [DATA_W-1:0] GAIN_MASK = (ONE_W << GAIN_W) - ONE_W;
  localparam logic [1:0] SEL_OFS  = 2'd0;
  localparam logic [1:0] SEL_GAIN = 2'd1;
  localparam logic [1:0] SEL_CFG  = 2'd2;
  localparam logic [1:0] SEL_NONE = 2'd3;

  typedef enum logic [1:0] {M_CMD, M_WR, M_RD} mode_t;

  mode_t              mode_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [DATA_W-2:0]  sh_q;
  logic [DATA_W-1:0]  tx_q;
  logic [DATA_W-1:0]  offset_q, gain_q, cfg_q;
  logic [1:0]         sel_q;
  logic [ONES_W-1:0]  ones_q;
  logic               miso_q;

  logic [CMD_W-1:0]  cmd_byte;
  logic [DATA_W-1:0] word_in, rd_word;
  logic cmd_ok, resync_hit, last_cmd_bit, last_data_bit, wr_fire, srst_fire;

  assign cmd_byte      = {sh_q[CMD_W-2:0], mosi};
  assign word_in       = {sh_q, mosi};
  assign cmd_ok        = (cmd_byte[CMD_W-1:4] == '0) && !cmd_byte[0] && (cmd_byte[2:1] != SEL_NONE);
  assign resync_hit    = !mosi && (ones_q == ONES_W'(ONES_MAX));
  assign last_cmd_bit  = (mode_q == M_CMD) && (cnt_q == CNT_W'(CMD_W - 1));
  assign last_data_bit = (mode_q != M_CMD) && (cnt_q == CNT_W'(DATA_W - 1));
  assign wr_fire       = !cs_n && !resync_hit && (mode_q == M_WR) && last_data_bit;
  assign srst_fire     = wr_fire && (sel_q == SEL_CFG) && word_in[SRST_BIT];

  always_comb begin
    unique case (cmd_byte[2:1])
      SEL_OFS:  rd_word = offset_q;
      SEL_GAIN: rd_word = gain_q;
      SEL_CFG:  rd_word = cfg_q;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge sclk) begin
    if (!cs_n) begin
      ones_q <= !mosi ? '0 : (ones_q == ONES_W'(ONES_MAX)) ? ones_q : ones_q + 1'b1;
      sh_q   <= word_in[DATA_W-2:0];
      if (resync_hit) begin
        mode_q <= M_CMD;
        cnt_q  <= '0;
      end else if (mode_q == M_CMD) begin
        if (last_cmd_bit) begin
          cnt_q <= '0;
          if (cmd_ok) begin
            sel_q  <= cmd_byte[2:1];
            mode_q <= cmd_byte[3] ? M_RD : M_WR;
            tx_q   <= rd_word;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
        tx_q  <= tx_q << 1;
        if (last_data_bit) begin
          mode_q <= M_CMD;
          cnt_q  <= '0;
        end
      end
    end
  end

  always_ff @(posedge sclk) begin
    if (srst_fire) begin
      offset_q <= '0;
      gain_q   <= GAIN_ONE;
      cfg_q    <= '0;
    end else if (wr_fire) begin
      unique case (sel_q)
        SEL_OFS:  offset_q <= word_in;
        SEL_GAIN: gain_q   <= word_in & GAIN_MASK;
        SEL_CFG:  cfg_q    <= word_in;
        default:  ;
      endcase
    end
  end

  always_ff @(negedge sclk) begin
    miso_q <= (!cs_n && mode_q == M_RD) ? tx_q[DATA_W-1] : 1'b0;
  end

  assign miso        = miso_q & !cs_n;
  assign offset_cal  = offset_q;
  assign gain_cal    = gain_q;
  assign cfg_word    = cfg_q;
  assign input_short = cfg_q[SHORT_BIT];
  assign vref_sel    = cfg_q[VREF_BIT];

  AST_RESYNC_TO_CMD: assert property (@(posedge sclk) disable iff (cs_n)
    resync_hit |=> (mode_q == M_CMD && cnt_q == '0)); // R6
  AST_ONES_SATURATE: assert property (@(posedge sclk) disable iff (cs_n)
    (ones_q == ONES_W'(ONES_MAX) && mosi) |=> (ones_q == ONES_W'(ONES_MAX))); // R6
  AST_BAD_CMD_STAYS: assert property (@(posedge sclk) disable iff (cs_n)
    (last_cmd_bit && !resync_hit && !cmd_ok) |=> (mode_q == M_CMD && cnt_q == '0)); // R2
  AST_CMD_KEEPS_REGS: assert property (@(posedge sclk) disable iff (cs_n)
    (mode_q == M_CMD) |=> ($stable(offset_q) && $stable(gain_q) && $stable(cfg_q))); // R3
  AST_GAIN_TOP_ZERO: assert property (@(posedge sclk) disable iff (cs_n)
    (wr_fire && sel_q == SEL_GAIN) |=> (gain_q[DATA_W-1:GAIN_W] == '0)); // R5
  AST_SRST_DEFAULTS: assert property (@(posedge sclk) disable iff (cs_n)
    srst_fire |=> (offset_q == '0 && gain_q == GAIN_ONE && cfg_q == '0)); // R8
endmodule

// File: tb/serial_cmd_port_tb.sv
`timescale 1ns/1ps
module serial_cmd_port_tb;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso, input_short, vref_sel;
  logic [31:0] offset_cal, gain_cal, cfg_word;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 sclk = ~sclk;

  serial_cmd_port u_dut (
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .offset_cal(offset_cal), .gain_cal(gain_cal), .cfg_word(cfg_word),
    .input_short(input_short), .vref_sel(vref_sel)
  );

  // {select, write data, expected read-back}
  localparam logic [65:0] VEC [0:6] = '{
    {2'd0, 32'h1234_5678, 32'h1234_5678},
    {2'd1, 32'hFFFF_FFFF, 32'h3FFF_FFFF},
    {2'd2, 32'h0A00_0000, 32'h0A00_0000},
    {2'd0, 32'h8000_0001, 32'h8000_0001},
    {2'd1, 32'hC080_0000, 32'h0080_0000},
    {2'd2, 32'h0800_00F0, 32'h0800_00F0},
    {2'd2, 32'h0200_0003, 32'h0200_0003}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    @(negedge sclk);
    cs_n = 1'b0;
    mosi = b;
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic idle();
    @(negedge sclk);
    cs_n = 1'b1;
    mosi = 1'b0;
    #1;
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [31:0] d, output logic [31:0] rx);
    put_byte(cmd);
    for (int i = 31; i >= 0; i--) begin
      @(negedge sclk);
      cs_n = 1'b0;
      mosi = d[i];
      #1 rx[i] = miso;
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    logic [31:0] r;
    xfer({4'b0, 1'b0, s, 1'b0}, d, r);
    chk("R4 miso low during write", r, 32'h0);
    idle();
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] r);
    xfer({4'b0, 1'b1, s, 1'b0}, 32'h0, r);
    idle();
  endtask

  task automatic resync(input int n);
    for (int i = 0; i < n; i++) put_byte(8'hFF);
    put_byte(8'hFE);
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #750000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] exp_ofs, exp_gain;
    repeat (4) @(negedge sclk);

    // Initialization: recovery pattern then soft reset (R6, R8)
    resync(15);
    wr(2'd2, 32'h2000_0000);
    chk("R8 reset offset", offset_cal, 32'h0);
    chk("R8 reset gain", gain_cal, 32'h0100_0000);
    chk("R8 reset config", cfg_word, 32'h0);
    chk("R9 reset flags", {30'b0, input_short, vref_sel}, 32'h0);
    rd(2'd2, r);
    chk("R8 soft reset bit self-clears", r, 32'h0);
    rd(2'd1, r);
    chk("R4 read gain default", r, 32'h0100_0000);
    chk("R4 miso low with cs_n high", {31'b0, miso}, 32'h0);

    // Table walk: write, port value, read back (R1 R3 R4 R5 R9)
    exp_ofs = 32'h0;
    exp_gain = 32'h0100_0000;
    for (int i = 0; i < 7; i++) begin
      logic [1:0]  s;
      logic [31:0] d, e;
      {s, d, e} = VEC[i];
      wr(s, d);
      case (s)
        2'd0: begin chk("R3 offset port after write", offset_cal, e); exp_ofs = e; end
        2'd1: begin chk("R5 gain port after write", gain_cal, e); exp_gain = e; end
        default: begin
          chk("R3 config port after write", cfg_word, e);
          chk("R9 input_short flag", {31'b0, input_short}, {31'b0, e[27]});
          chk("R9 vref_sel flag", {31'b0, vref_sel}, {31'b0, e[25]});
        end
      endcase
      rd(s, r);
      chk("R1 R4 read back", r, e);
    end

    // Invalid commands are discarded, next byte is a command (R2)
    put_byte(8'h06);
    put_byte(8'h10);
    put_byte(8'h01);
    chk("R2 offset unchanged by bad commands", offset_cal, exp_ofs);
    wr(2'd0, 32'h1111_1111);
    chk("R2 write after bad commands", offset_cal, 32'h1111_1111);
    rd(2'd1, r);
    chk("R2 gain intact", r, exp_gain);

    // Pause with chip select high mid-write (R10)
    put_byte(8'h02);
    for (int i = 31; i >= 16; i--) put_bit(32'h00C0_FFEE >> i);
    @(negedge sclk);
    cs_n = 1'b1;
    repeat (10) @(negedge sclk);
    #1 chk("R10 gain held during pause", gain_cal, exp_gain);
    for (int i = 15; i >= 0; i--) put_bit(32'h00C0_FFEE >> i);
    idle();
    chk("R10 gain after resumed write", gain_cal, 32'h00C0_FFEE);

    // Soft reset with other flags in the same word (R8)
    wr(2'd2, 32'h2A00_0000);
    chk("R8 offset default", offset_cal, 32'h0);
    chk("R8 gain default", gain_cal, 32'h0100_0000);
    chk("R8 config default", cfg_word, 32'h0);

    // Short run: 3 stray ones + 14 x FF + FE leaves phase broken (R7)
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    resync(14);
    begin
      logic [31:0] rr;
      xfer(8'h00, 32'hA55A_C33C, rr);
    end
    idle();
    chk("R7 short run does not realign", offset_cal, 32'h0);

    // Full run realigns from the broken phase (R6)
    resync(15);
    wr(2'd0, 32'h5555_AAAA);
    chk("R6 realigned write", offset_cal, 32'h5555_AAAA);

    // Very long run past saturation still realigns (R6)
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    resync(40);
    wr(2'd1, 32'h00AB_CDEF);
    chk("R6 saturated run realigns", gain_cal, 32'h00AB_CDEF);
    rd(2'd0, r);
    chk("R6 offset read after long run", r, 32'h5555_AAAA);

    done = 1'b1;
    report();
  end
endmodule